// File: doc/BRIEF.md
# Four-Port Serial Register Interface

This block sits between a processor bus and four asynchronous serial transceivers. It decodes bus reads and writes, keeps the control bits for each port, and returns 16-bit status and data words. Each port has four word registers: receive status, receive data, transmit status and transmit data. The block drives the control bits straight to the transceivers, the modem lines and the interrupt logic. For a transmit-data write it sends a byte and a one-cycle load strobe. For a receive-data read it sends a one-cycle strobe that clears data-available.

The processor puts an address on `busAddr`, sets `writeEn` for a write, and raises `addrValid`. The block acts once per `addrValid` assertion. It latches any read word, raises `ack` and holds both until `addrValid` falls. An access whose card field does not match, or whose port field names a port that does not exist, does nothing and gets no acknowledge.

Top module: `serial_port_regs`

## Requirements
- R1: Address bits 15:6 must equal the `CARD_ID` parameter (default 0x3F5), and bits 5:3 must name port 0 to 3. Otherwise the access is ignored: no `ack`, no strobe and no change to any control bit. Bits 2:1 select the register: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data. Bit 0 is unused.
- R2: A transmit-status write sets the port's break, loopback and transmit-interrupt-enable outputs from data bits 0, 2 and 6. These take effect in the cycle after the access edge.
- R3: A transmit-status read returns break in bit 0, loopback in bit 2, transmit interrupt enable in bit 6 and the port's `txEmpty` in bit 7. All other bits are zero.
- R4: A receive-status write sets the port's reader-enable from bit 0 and its receive interrupt enable from bit 6. For port 0 only, it also sets `dtrOut` from bit 1 and `rtsOut` from bit 2. On other ports, bits 1 and 2 have no effect.
- R5: A port's reader-enable clears on any clock edge where that port's `serIn` is low (a start bit). A receive-status write to that port on the same edge takes precedence.
- R6: A receive-status read returns the stored bits 1, 2 and 6 and `rxAvail` in bit 7. For port 0 only, it adds DSR in bit 9, carrier in bit 12, CTS in bit 13 and ring in bit 14. Other ports return zero in bits 1, 2, 9 and 12 to 14.
- R7: A receive-data read returns the character in bits 7:0, parity error in bit 12, overrun in bit 14 and their OR in bit 15. It issues a one-cycle `rxDataAck` pulse to that port.
- R8: A transmit-data write puts data bits 7:0 on `txData` and issues a one-cycle `txLoad` pulse to that port. Writes to the receive-data register change nothing. Reads of the transmit-data register return zero.
- R9: `ack` rises on the edge after a matched access begins and stays high while `addrValid` is held. It falls at the first edge where `addrValid` is low. `rdData` stays stable during that time. One `addrValid` assertion performs exactly one access, however long it is held.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Address valid, marks a bus access |
| writeEn | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Card, port and register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Latched read word |
| ack | output | 1 | Access acknowledge |
| txEmpty | input | 4 | Per-port transmit buffer empty |
| rxAvail | input | 4 | Per-port received data waiting |
| rxChar | input | 32 | Per-port received character, port p in bits 8p+7:8p |
| parErr | input | 4 | Per-port parity error |
| ovrErr | input | 4 | Per-port overrun error |
| serIn | input | 4 | Per-port serial input level |
| dsrIn | input | 1 | Port 0 data set ready |
| dcdIn | input | 1 | Port 0 carrier detect |
| ctsIn | input | 1 | Port 0 clear to send |
| riIn | input | 1 | Port 0 ring indicator |
| brkEn | output | 4 | Per-port break enable |
| loopEn | output | 4 | Per-port loopback enable |
| txIntEn | output | 4 | Per-port transmit interrupt enable |
| rxIntEn | output | 4 | Per-port receive interrupt enable |
| readerEn | output | 4 | Per-port reader enable |
| dtrOut | output | 1 | Port 0 data terminal ready |
| rtsOut | output | 1 | Port 0 request to send |
| txData | output | 8 | Transmit byte |
| txLoad | output | 4 | Per-port one-cycle transmit load strobe |
| rxDataAck | output | 4 | Per-port one-cycle data-available reset |

## Verification
The hardest case to reach from the ports is the interaction between a long-held `addrValid` and the one-shot strobes. The bench holds a transmit-data write for several cycles and counts the `txLoad` pulses. Reader-enable clearing is reached by pulling one port's `serIn` low for a single cycle between bus accesses. The bench then confirms that only that port's output dropped. Decode rejection is reached with a wrong card field and with port field 5. A cycle-accurate behavioural model in the bench checks that neither access acknowledges nor changes state.

// File: rtl/spr_pkg.sv
package spr_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_W    = $clog2(NUM_PORTS);
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 16;
  localparam int CHAR_W    = 8;
  localparam int CARD_W    = ADDR_W - 6;

  typedef enum logic [1:0] {
    FN_RX_STAT = 2'd0,
    FN_RX_DATA = 2'd1,
    FN_TX_STAT = 2'd2,
    FN_TX_DATA = 2'd3
  } regFn_t;

  typedef struct packed {
    logic              go;
    logic              wr;
    logic [PORT_W-1:0] port;
    regFn_t            fn;
  } busCmd_t;

  typedef struct packed {
    logic brk;
    logic loop;
    logic txIe;
    logic rxIe;
    logic rdrEn;
  } portCtl_t;
endpackage

// File: rtl/spr_bus_ctrl.sv
module spr_bus_ctrl
  import spr_pkg::*;
#(
  parameter logic [CARD_W-1:0] CARD_ID = CARD_W'('h3F5)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busCmd_t           cmd,
  output logic              ack
);
  logic       avPrev;
  logic       cardHit;
  logic       portHit;
  logic [2:0] portField;
  logic       unusedAddr;

  assign portField  = busAddr[5:3];
  assign cardHit    = (busAddr[ADDR_W-1:6] == CARD_ID);
  assign portHit    = (portField < 3'(NUM_PORTS));
  assign unusedAddr = busAddr[0];

  always_comb begin
    cmd.go   = addrValid & ~avPrev & cardHit & portHit;
    cmd.wr   = writeEn;
    cmd.port = portField[PORT_W-1:0];
    cmd.fn   = regFn_t'(busAddr[2:1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      avPrev <= 1'b0;
      ack    <= 1'b0;
    end else begin
      avPrev <= addrValid;
      if (!addrValid)  ack <= 1'b0;
      else if (cmd.go) ack <= 1'b1;
    end
  end
endmodule

// File: rtl/spr_port_regs.sv
module spr_port_regs
  import spr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  busCmd_t                     cmd,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [NUM_PORTS-1:0]        txEmpty,
  input  logic [NUM_PORTS-1:0]        rxAvail,
  input  logic [NUM_PORTS*CHAR_W-1:0] rxChar,
  input  logic [NUM_PORTS-1:0]        parErr,
  input  logic [NUM_PORTS-1:0]        ovrErr,
  input  logic [NUM_PORTS-1:0]        serIn,
  input  logic                        dsrIn,
  input  logic                        dcdIn,
  input  logic                        ctsIn,
  input  logic                        riIn,
  output logic [NUM_PORTS-1:0]        brkEn,
  output logic [NUM_PORTS-1:0]        loopEn,
  output logic [NUM_PORTS-1:0]        txIntEn,
  output logic [NUM_PORTS-1:0]        rxIntEn,
  output logic [NUM_PORTS-1:0]        readerEn,
  output logic                        dtrOut,
  output logic                        rtsOut,
  output logic [CHAR_W-1:0]           txData,
  output logic [NUM_PORTS-1:0]        txLoad,
  output logic [NUM_PORTS-1:0]        rxDataAck,
  output logic [DATA_W-1:0]           rdData
);
  portCtl_t          ctl    [NUM_PORTS];
  logic [DATA_W-1:0] rdWord [NUM_PORTS];
  logic              wrRxStat, wrTxStat, wrTxData, rdRxData;
  logic              unusedData;

  assign wrRxStat   = cmd.go &  cmd.wr & (cmd.fn == FN_RX_STAT);
  assign wrTxStat   = cmd.go &  cmd.wr & (cmd.fn == FN_TX_STAT);
  assign wrTxData   = cmd.go &  cmd.wr & (cmd.fn == FN_TX_DATA);
  assign rdRxData   = cmd.go & ~cmd.wr & (cmd.fn == FN_RX_DATA);
  assign unusedData = ^{wrData[DATA_W-1:CHAR_W], wrData[5:3]};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic sel;
    assign sel = (cmd.port == PORT_W'(p));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctl[p]       <= '0;
        txLoad[p]    <= 1'b0;
        rxDataAck[p] <= 1'b0;
      end else begin
        if (sel && wrTxStat) begin
          ctl[p].brk  <= wrData[0];
          ctl[p].loop <= wrData[2];
          ctl[p].txIe <= wrData[6];
        end
        if (sel && wrRxStat) begin
          ctl[p].rdrEn <= wrData[0];
          ctl[p].rxIe  <= wrData[6];
        end else if (!serIn[p]) begin
          ctl[p].rdrEn <= 1'b0;
        end
        txLoad[p]    <= sel & wrTxData;
        rxDataAck[p] <= sel & rdRxData;
      end
    end

    always_comb begin
      rdWord[p] = '0;
      unique case (cmd.fn)
        FN_RX_STAT: begin
          rdWord[p][6] = ctl[p].rxIe;
          rdWord[p][7] = rxAvail[p];
          if (p == 0) begin
            rdWord[p][1]  = dtrOut;
            rdWord[p][2]  = rtsOut;
            rdWord[p][9]  = dsrIn;
            rdWord[p][12] = dcdIn;
            rdWord[p][13] = ctsIn;
            rdWord[p][14] = riIn;
          end
        end
        FN_RX_DATA: begin
          rdWord[p][CHAR_W-1:0] = rxChar[p*CHAR_W +: CHAR_W];
          rdWord[p][12]         = parErr[p];
          rdWord[p][14]         = ovrErr[p];
          rdWord[p][15]         = parErr[p] | ovrErr[p];
        end
        FN_TX_STAT: begin
          rdWord[p][0] = ctl[p].brk;
          rdWord[p][2] = ctl[p].loop;
          rdWord[p][6] = ctl[p].txIe;
          rdWord[p][7] = txEmpty[p];
        end
        default: rdWord[p] = '0;
      endcase
    end

    assign brkEn[p]    = ctl[p].brk;
    assign loopEn[p]   = ctl[p].loop;
    assign txIntEn[p]  = ctl[p].txIe;
    assign rxIntEn[p]  = ctl[p].rxIe;
    assign readerEn[p] = ctl[p].rdrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dtrOut <= 1'b0;
      rtsOut <= 1'b0;
      txData <= '0;
      rdData <= '0;
    end else begin
      if (wrRxStat && cmd.port == '0) begin
        dtrOut <= wrData[1];
        rtsOut <= wrData[2];
      end
      if (wrTxData) txData <= wrData[CHAR_W-1:0];
      if (cmd.go && !cmd.wr) rdData <= rdWord[cmd.port];
    end
  end
endmodule

// File: rtl/serial_port_regs.sv
module serial_port_regs
  import spr_pkg::*;
#(
  parameter logic [CARD_W-1:0] CARD_ID = CARD_W'('h3F5)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        addrValid,
  input  logic                        writeEn,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic                        ack,
  input  logic [NUM_PORTS-1:0]        txEmpty,
  input  logic [NUM_PORTS-1:0]        rxAvail,
  input  logic [NUM_PORTS*CHAR_W-1:0] rxChar,
  input  logic [NUM_PORTS-1:0]        parErr,
  input  logic [NUM_PORTS-1:0]        ovrErr,
  input  logic [NUM_PORTS-1:0]        serIn,
  input  logic                        dsrIn,
  input  logic                        dcdIn,
  input  logic                        ctsIn,
  input  logic                        riIn,
  output logic [NUM_PORTS-1:0]        brkEn,
  output logic [NUM_PORTS-1:0]        loopEn,
  output logic [NUM_PORTS-1:0]        txIntEn,
  output logic [NUM_PORTS-1:0]        rxIntEn,
  output logic [NUM_PORTS-1:0]        readerEn,
  output logic                        dtrOut,
  output logic                        rtsOut,
  output logic [CHAR_W-1:0]           txData,
  output logic [NUM_PORTS-1:0]        txLoad,
  output logic [NUM_PORTS-1:0]        rxDataAck
);
  busCmd_t cmd;

  spr_bus_ctrl #(.CARD_ID(CARD_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .writeEn(writeEn),
    .busAddr(busAddr), .cmd(cmd), .ack(ack)
  );

  spr_port_regs u_regs (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .txEmpty(txEmpty), .rxAvail(rxAvail), .rxChar(rxChar),
    .parErr(parErr), .ovrErr(ovrErr), .serIn(serIn),
    .dsrIn(dsrIn), .dcdIn(dcdIn), .ctsIn(ctsIn), .riIn(riIn),
    .brkEn(brkEn), .loopEn(loopEn), .txIntEn(txIntEn), .rxIntEn(rxIntEn),
    .readerEn(readerEn), .dtrOut(dtrOut), .rtsOut(rtsOut),
    .txData(txData), .txLoad(txLoad), .rxDataAck(rxDataAck), .rdData(rdData)
  );
endmodule

// File: rtl/spr_checks.sv
module spr_checks
  import spr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 addrValid,
  input logic [NUM_PORTS-1:0] serIn,
  input logic                 ack,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_PORTS-1:0] txLoad,
  input logic [NUM_PORTS-1:0] rxDataAck,
  input logic [NUM_PORTS-1:0] readerEn,
  input logic [NUM_PORTS-1:0] brkEn
);
  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> !ack);

  // R9
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ack) |-> $past(addrValid));

  // R9
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && addrValid) |=> $stable(rdData));

  // R8
  txload_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txLoad));

  // R8
  txload_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|txLoad) |=> !(|txLoad));

  // R7
  rxack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|rxDataAck) |=> (!(|rxDataAck) && $onehot0(rxDataAck)));

  // R2
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> $stable(brkEn));

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_rdr
    // R5
    reader_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!addrValid && !serIn[k]) |=> !readerEn[k]);
  end
endmodule

bind serial_port_regs spr_checks u_checks (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .serIn(serIn),
  .ack(ack), .rdData(rdData), .txLoad(txLoad), .rxDataAck(rxDataAck),
  .readerEn(readerEn), .brkEn(brkEn)
);

// File: tb/test_serial_port_regs.sv
`timescale 1ns/1ps
module test_serial_port_regs;
  localparam logic [9:0] CARD = 10'h3F5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0, writeEn = 1'b0;
  logic [15:0] busAddr = '0, wrData = '0;
  logic [15:0] rdData;
  logic        ack;
  logic [3:0]  txEmpty = '0, rxAvail = '0, parErr = '0, ovrErr = '0, serIn = 4'hF;
  logic [31:0] rxChar = '0;
  logic        dsrIn = 0, dcdIn = 0, ctsIn = 0, riIn = 0;
  logic [3:0]  brkEn, loopEn, txIntEn, rxIntEn, readerEn, txLoad, rxDataAck;
  logic        dtrOut, rtsOut;
  logic [7:0]  txData;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_port_regs i_serial_port_regs (.*);

  // Behavioural reference model
  bit        mAvPrev, mAck, mDtr, mRts;
  bit [15:0] mRd;
  bit [7:0]  mTxData;
  bit [3:0]  mBrk, mLoop, mTxIe, mRxIe, mRe, mTxLoad, mRxAck;

  function automatic bit [15:0] expWord(int p, int f);
    bit [15:0] w = 0;
    case (f)
      0: begin
        w[6] = mRxIe[p]; w[7] = rxAvail[p];
        if (p == 0) begin
          w[1] = mDtr; w[2] = mRts; w[9] = dsrIn;
          w[12] = dcdIn; w[13] = ctsIn; w[14] = riIn;
        end
      end
      1: begin
        w[7:0] = rxChar[p*8 +: 8]; w[12] = parErr[p];
        w[14] = ovrErr[p]; w[15] = parErr[p] | ovrErr[p];
      end
      2: begin
        w[0] = mBrk[p]; w[2] = mLoop[p]; w[6] = mTxIe[p]; w[7] = txEmpty[p];
      end
      default: w = 0;
    endcase
    return w;
  endfunction

  always @(posedge clk) begin
    bit hit;
    int pp, f;
    if (!rstN) begin
      mAvPrev <= 0; mAck <= 0; mDtr <= 0; mRts <= 0; mRd <= 0; mTxData <= 0;
      mBrk <= 0; mLoop <= 0; mTxIe <= 0; mRxIe <= 0; mRe <= 0;
      mTxLoad <= 0; mRxAck <= 0;
    end else begin
      hit = addrValid && !mAvPrev && busAddr[15:6] == CARD && busAddr[5:3] < 4;
      mAvPrev <= addrValid;
      if (!addrValid) mAck <= 0; else if (hit) mAck <= 1;
      mTxLoad <= 0; mRxAck <= 0;
      for (int p = 0; p < 4; p++) if (!serIn[p]) mRe[p] <= 0;
      if (hit) begin
        pp = int'(busAddr[4:3]); f = int'(busAddr[2:1]);
        if (writeEn) begin
          case (f)
            0: begin
              mRe[pp] <= wrData[0]; mRxIe[pp] <= wrData[6];
              if (pp == 0) begin mDtr <= wrData[1]; mRts <= wrData[2]; end
            end
            2: begin mBrk[pp] <= wrData[0]; mLoop[pp] <= wrData[2]; mTxIe[pp] <= wrData[6]; end
            3: begin mTxData <= wrData[7:0]; mTxLoad[pp] <= 1; end
            default: ;
          endcase
        end else begin
          mRd <= expWord(pp, f);
          if (f == 1) mRxAck[pp] <= 1;
        end
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R9 model ack", {31'd0, ack}, {31'd0, mAck});
      check("R7 model rdData", {16'd0, rdData}, {16'd0, mRd});
      check("R2 model control",
            {6'd0, brkEn, loopEn, txIntEn, rxIntEn, readerEn, dtrOut, rtsOut},
            {6'd0, mBrk, mLoop, mTxIe, mRxIe, mRe, mDtr, mRts});
      check("R8 model strobes", {16'd0, txData, txLoad, rxDataAck},
            {16'd0, mTxData, mTxLoad, mRxAck});
    end
  end

  function automatic logic [15:0] ad(logic [9:0] card, int port, int fn);
    return {card, 3'(port), 2'(fn), 1'b0};
  endfunction

  task automatic doWrite(input logic [15:0] a, input logic [15:0] d,
                         output logic ackSeen, output logic [3:0] ldSeen);
    @(negedge clk); busAddr = a; wrData = d; writeEn = 1; addrValid = 1;
    @(negedge clk); ackSeen = ack; ldSeen = txLoad;
    addrValid = 0; writeEn = 0;
    @(negedge clk);
  endtask

  task automatic doRead(input logic [15:0] a, output logic [15:0] data,
                        output logic ackSeen, output logic [3:0] raSeen);
    @(negedge clk); busAddr = a; writeEn = 0; addrValid = 1;
    @(negedge clk); data = rdData; ackSeen = ack; raSeen = rxDataAck;
    addrValid = 0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic        a;
    logic [3:0]  s;
    logic [15:0] d;
    int          pulses;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {ack, rdData, brkEn, loopEn, txIntEn, rxIntEn, readerEn,
                        dtrOut, rtsOut, txData, txLoad, rxDataAck}, '0);

    // R2 transmit status write
    doWrite(ad(CARD, 1, 2), 16'h0045, a, s);
    check("R2 ack", {31'd0, a}, 32'd1);
    check("R2 brk/loop/txIe", {brkEn, loopEn, txIntEn}, {4'b0010, 4'b0010, 4'b0010});

    // R3 transmit status read
    txEmpty = 4'b0010;
    doRead(ad(CARD, 1, 2), d, a, s);
    check("R3 ts read empty", {16'd0, d}, 32'h00C5);
    txEmpty = 4'b0000;
    doRead(ad(CARD, 1, 2), d, a, s);
    check("R3 ts read busy", {16'd0, d}, 32'h0045);

    // R4 receive status write, port 0
    doWrite(ad(CARD, 0, 0), 16'h0047, a, s);
    check("R4 port0", {readerEn, rxIntEn, 2'b00, dtrOut, rtsOut},
          {4'b0001, 4'b0001, 2'b00, 1'b1, 1'b1});

    // R6 receive status read, port 0 with modem lines
    rxAvail = 4'b0001; dsrIn = 1; riIn = 1;
    doRead(ad(CARD, 0, 0), d, a, s);
    check("R6 port0 rs read", {16'd0, d}, 32'h42C6);

    // R4 port 2 ignores bits 1,2
    rxAvail = 0;
    doWrite(ad(CARD, 2, 0), 16'h0041, a, s);
    check("R4 port2", {readerEn, rxIntEn, 2'b00, dtrOut, rtsOut},
          {4'b0101, 4'b0101, 2'b00, 1'b1, 1'b1});
    doRead(ad(CARD, 2, 0), d, a, s);
    check("R6 port2 no modem", {16'd0, d}, 32'h0040);

    // R5 start bit clears reader enable of that port only
    @(negedge clk); serIn = 4'b1011;
    @(negedge clk); serIn = 4'hF;
    check("R5 reader clear", {28'd0, readerEn}, 32'h1);

    // R7 receive data read with parity error
    rxChar = 32'h0000_0000; rxChar[31:24] = 8'hA5; parErr = 4'b1000;
    doRead(ad(CARD, 3, 1), d, a, s);
    check("R7 rd parity", {16'd0, d}, 32'h90A5);
    check("R7 rxDataAck pulse", {28'd0, s}, 32'h8);
    check("R7 pulse gone", {28'd0, rxDataAck}, 32'h0);
    parErr = 0; ovrErr = 4'b0010; rxChar[15:8] = 8'h3C;
    doRead(ad(CARD, 1, 1), d, a, s);
    check("R7 rd overrun", {16'd0, d}, 32'hC03C);
    ovrErr = 0;

    // R8 transmit data write
    doWrite(ad(CARD, 2, 3), 16'h1234, a, s);
    check("R8 txLoad", {28'd0, s}, 32'h4);
    check("R8 txData", {24'd0, txData}, 32'h34);
    doWrite(ad(CARD, 1, 1), 16'h00FF, a, s);
    check("R8 rx data write ignored", {20'd0, txData, s}, {20'd0, 8'h34, 4'h0});
    doRead(ad(CARD, 0, 3), d, a, s);
    check("R8 td read zero", {16'd0, d}, 32'h0);

    // R1 decode rejection
    doWrite(ad(10'h3F6, 0, 2), 16'h0045, a, s);
    check("R1 wrong card ack", {31'd0, a}, 32'd0);
    check("R1 wrong card state", {28'd0, brkEn}, 32'h2);
    doWrite(ad(CARD, 5, 2), 16'h0045, a, s);
    check("R1 port5 ack", {31'd0, a}, 32'd0);
    check("R1 port5 state", {28'd0, brkEn}, 32'h2);

    // R9 long access: single action
    pulses = 0;
    @(negedge clk); busAddr = ad(CARD, 3, 3); wrData = 16'h0077; writeEn = 1; addrValid = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (txLoad != 0) pulses++;
      check("R9 ack held", {31'd0, ack}, 32'd1);
    end
    addrValid = 0; writeEn = 0;
    @(negedge clk);
    check("R9 ack fall", {31'd0, ack}, 32'd0);
    check("R9 one load", pulses, 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule